// File: doc/BRIEF.md
# Clear-to-send transmit gate

This block sits between a byte producer and a UART transmitter that talks to a slow peripheral with a clear-to-send wire. The transmitter's own ready flag only says that the line is free. It says nothing about whether the far end can take another byte. The two flags change at unrelated times. After a byte goes out, the transmitter can report ready again before the peripheral has dropped clear-to-send. A gate that looked only at the two levels would therefore send the next byte too early.

The gate releases one byte at a time. After each write it waits to see the synchronized clear-to-send level fall and then rise. Only then, and only once the transmitter is ready again, does it offer the next slot to the producer. A strobe offered outside that slot is dropped and reported with a one-cycle overrun pulse. A watchdog counts bit-period ticks after a write. If clear-to-send never falls within a programmable number of ticks, the watchdog reports a timeout pulse and reopens the gate.

Top module: `cts_tx_gate`

## Requirements
- R1: While reset is held, and after it is released, `tx_we`, `send_ready`, `overrun` and `timeout` are 0. `send_ready` stays 0 until both `tx_ready` and the synchronized clear-to-send level are high.
- R2: `send_ready` is high only when the gate is idle and both `tx_ready` and the synchronized clear-to-send level are high.
- R3: A `send_valid` strobe that meets `send_ready` high produces exactly one `tx_we` pulse on the next cycle, with `tx_data` equal to the strobed `send_data`.
- R4: After a write, `send_ready` stays low until clear-to-send has been seen low and then high again. This holds even if `tx_ready` falls and rises in the meantime.
- R5: Once clear-to-send has risen after a write, `send_ready` returns as soon as `tx_ready` is high. It stays low while `tx_ready` is low.
- R6: A `send_valid` strobe while `send_ready` is low causes no write. It raises `overrun` for one cycle on the next cycle.
- R7: If clear-to-send does not fall within `wd_limit` cycles with `bit_tick` high after a write, `timeout` pulses on the cycle after the tick that reaches the limit, and the gate returns to idle. A limit of 0 behaves as a limit of 1.
- R8: `cts_in` passes through two flip-flops before use. A change in `cts_in` reaches `send_ready` two clock edges after it is sampled, and no earlier.
- R9: `timeout` is never high on two consecutive cycles, and `overrun` falls after a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ready | input | 1 | Transmitter can accept a byte |
| cts_in | input | 1 | Asynchronous clear-to-send level from the peripheral |
| send_valid | input | 1 | Producer strobe: send `send_data` |
| send_data | input | 8 | Byte offered by the producer |
| bit_tick | input | 1 | One pulse per bit period, used by the watchdog |
| wd_limit | input | 16 | Watchdog limit in bit periods |
| tx_we | output | 1 | Write strobe to the transmitter |
| tx_data | output | 8 | Byte written to the transmitter |
| send_ready | output | 1 | Producer may strobe this cycle |
| overrun | output | 1 | One-cycle pulse: a strobe was dropped |
| timeout | output | 1 | One-cycle pulse: clear-to-send never fell after a write |

## Verification
The assertions assume that `tx_ready` and `send_valid` are synchronous to `clk`. They also assume that `wd_limit` holds steady while a write is pending. Only `cts_in` may change at arbitrary times. The stimulus drives every input on the falling clock edge. It holds `wd_limit` fixed and keeps `bit_tick` low except in the watchdog test. Clear-to-send levels are held for several cycles, so every fall and rise passes cleanly through the synchronizer.

// File: rtl/cts_gate_pkg.sv
package cts_gate_pkg;

  typedef enum logic [1:0] {
    GATE_IDLE     = 2'd0,
    GATE_SENT     = 2'd1,
    GATE_CTS_BACK = 2'd2,
    GATE_TX_WAIT  = 2'd3
  } gate_state_t;

  // The watchdog expires when this tick would bring the count to the limit.
  // A limit of zero is treated as one.
  function automatic logic wd_expired(input logic [15:0] count,
                                      input logic [15:0] limit);
    logic [16:0] next_count;
    next_count = {1'b0, count} + 17'd1;
    return next_count >= {1'b0, limit};
  endfunction

endpackage

// File: rtl/cts_sync_edge.sv
module cts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_async,
  output logic cts_level,
  output logic cts_fell,
  output logic cts_rose
);
  logic [STAGES-1:0] chain;
  logic              level_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= cts_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= chain[STAGES-1];
  end

  assign cts_level = chain[STAGES-1];
  assign cts_fell  = level_d & ~chain[STAGES-1];
  assign cts_rose  = ~level_d & chain[STAGES-1];
endmodule

// File: rtl/cts_watchdog.sv
module cts_watchdog
  import cts_gate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] count;

  assign expire = armed && tick &&
                  wd_expired(16'(count), 16'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n || !armed) count <= '0;
    else if (tick && !expire) count <= count + 1'b1;
  end
endmodule

// File: rtl/cts_gate_fsm.sv
module cts_gate_fsm
  import cts_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_ready,
  input  logic        cts_level,
  input  logic        cts_fell,
  input  logic        cts_rose,
  input  logic        wd_expire,
  input  logic        strobe,
  output logic        open_slot,
  output logic        fire,
  output logic        wd_armed,
  output gate_state_t state
);
  gate_state_t next_state;

  assign open_slot = (state == GATE_IDLE) && tx_ready && cts_level;
  assign fire      = open_slot && strobe;
  assign wd_armed  = (state == GATE_SENT);

  always_comb begin
    next_state = state;
    unique case (state)
      GATE_IDLE:     if (fire) next_state = GATE_SENT;
      GATE_SENT:     if (cts_fell) next_state = GATE_CTS_BACK;
                     else if (wd_expire) next_state = GATE_IDLE;
      GATE_CTS_BACK: if (cts_rose) next_state = GATE_TX_WAIT;
      GATE_TX_WAIT:  if (tx_ready && cts_level) next_state = GATE_IDLE;
      default:       next_state = GATE_TX_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= GATE_TX_WAIT;
    else        state <= next_state;
  end
endmodule

// File: rtl/cts_tx_gate.sv
module cts_tx_gate
  import cts_gate_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_ready,
  input  logic              cts_in,
  input  logic              send_valid,
  input  logic [DATA_W-1:0] send_data,
  input  logic              bit_tick,
  input  logic [CNT_W-1:0]  wd_limit,
  output logic              tx_we,
  output logic [DATA_W-1:0] tx_data,
  output logic              send_ready,
  output logic              overrun,
  output logic              timeout
);
  logic        cts_sync;
  logic        cts_fell;
  logic        cts_rose;
  logic        wd_expire;
  logic        wd_armed;
  logic        fire;
  logic        drop;
  gate_state_t gate_state;

  cts_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts_async (cts_in),
    .cts_level (cts_sync),
    .cts_fell  (cts_fell),
    .cts_rose  (cts_rose)
  );

  cts_watchdog #(.CNT_W(CNT_W)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (wd_armed),
    .tick   (bit_tick),
    .limit  (wd_limit),
    .expire (wd_expire)
  );

  cts_gate_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_ready  (tx_ready),
    .cts_level (cts_sync),
    .cts_fell  (cts_fell),
    .cts_rose  (cts_rose),
    .wd_expire (wd_expire),
    .strobe    (send_valid),
    .open_slot (send_ready),
    .fire      (fire),
    .wd_armed  (wd_armed),
    .state     (gate_state)
  );

  assign drop = send_valid && !send_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_we   <= 1'b0;
      tx_data <= '0;
      overrun <= 1'b0;
      timeout <= 1'b0;
    end else begin
      tx_we   <= fire;
      if (fire) tx_data <= send_data;
      overrun <= drop;
      timeout <= wd_expire && !cts_fell;
    end
  end
endmodule

// File: rtl/cts_tx_gate_chk.sv
module cts_tx_gate_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              cts_sync,
  input logic              send_valid,
  input logic [DATA_W-1:0] send_data,
  input logic              send_ready,
  input logic              tx_we,
  input logic [DATA_W-1:0] tx_data,
  input logic              overrun,
  input logic              timeout
);
  assert_ready_needs_inputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    send_ready |-> (tx_ready && cts_sync));

  assert_write_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |-> $past(send_valid && send_ready));

  assert_write_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |-> (tx_data == $past(send_data)));

  assert_closed_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |-> !send_ready);

  assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(send_valid && !send_ready));

  assert_timeout_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
endmodule

bind cts_tx_gate cts_tx_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_ready   (tx_ready),
  .cts_sync   (cts_sync),
  .send_valid (send_valid),
  .send_data  (send_data),
  .send_ready (send_ready),
  .tx_we      (tx_we),
  .tx_data    (tx_data),
  .overrun    (overrun),
  .timeout    (timeout)
);

// File: tb/sim_cts_tx_gate.sv
module sim_cts_tx_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_ready = 1'b0;
  logic        cts_in = 1'b0;
  logic        send_valid = 1'b0;
  logic [7:0]  send_data = 8'h00;
  logic        bit_tick = 1'b0;
  logic [15:0] wd_limit = 16'd5;
  logic        tx_we;
  logic [7:0]  tx_data;
  logic        send_ready;
  logic        overrun;
  logic        timeout;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic done = 1'b0;

  always #4 clk = ~clk;

  cts_tx_gate u0 (
    .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .cts_in(cts_in),
    .send_valid(send_valid), .send_data(send_data), .bit_tick(bit_tick),
    .wd_limit(wd_limit), .tx_we(tx_we), .tx_data(tx_data),
    .send_ready(send_ready), .overrun(overrun), .timeout(timeout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every write must match the head of the scoreboard (R3).
  always @(negedge clk) begin
    if (rst_n && tx_we) begin
      if (exp_q.size() == 0) check("R3 unexpected write", {24'd0, tx_data}, 32'hFFFF_FFFF);
      else check("R3 write data", {24'd0, tx_data}, {24'd0, exp_q.pop_front()});
    end
  end

  // Driver: one strobe; expected writes go to the scoreboard.
  task automatic strobe(input logic [7:0] d, input logic accept);
    if (accept) exp_q.push_back(d);
    send_valid = 1'b1;
    send_data  = d;
    @(negedge clk);
    send_valid = 1'b0;
    check(accept ? "R3 no overrun" : "R6 overrun pulse", {31'd0, overrun}, {31'd0, !accept});
    @(negedge clk);
    check("R9 overrun falls", {31'd0, overrun}, 32'd0);
  endtask

  task automatic cts_cycle();
    cts_in = 1'b0;
    repeat (4) @(negedge clk);
    cts_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset tx_we", {31'd0, tx_we}, 32'd0);
    check("R1 reset ready", {31'd0, send_ready}, 32'd0);
    rst_n = 1'b1;
    tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready waits for cts", {31'd0, send_ready}, 32'd0);
    check("R1 no pulses", {30'd0, overrun, timeout}, 32'd0);
    cts_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 ready when idle", {31'd0, send_ready}, 32'd1);

    strobe(8'hA5, 1'b1);
    check("R4 closed after write", {31'd0, send_ready}, 32'd0);
    tx_ready = 1'b0;
    repeat (2) @(negedge clk);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 tx_ready alone not trusted", {31'd0, send_ready}, 32'd0);
    strobe(8'h11, 1'b0);
    cts_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 still closed while cts low", {31'd0, send_ready}, 32'd0);
    tx_ready = 1'b0;
    cts_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 waits for tx_ready", {31'd0, send_ready}, 32'd0);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R5 reopens", {31'd0, send_ready}, 32'd1);

    strobe(8'h3C, 1'b1);
    cts_cycle();
    check("R4 reopens after full cts cycle", {31'd0, send_ready}, 32'd1);
    strobe(8'h00, 1'b1);
    cts_cycle();
    strobe(8'hFF, 1'b1);
    cts_cycle();
    check("R2 idle again", {31'd0, send_ready}, 32'd1);

    // Watchdog: cts held high after a write.
    strobe(8'h5A, 1'b1);
    bit_tick = 1'b1;
    begin
      int n = 0;
      while (!timeout && n < 50) begin
        @(negedge clk);
        n++;
      end
      check("R7 timeout after limit ticks", n, 32'd5);
    end
    bit_tick = 1'b0;
    check("R7 reopened after timeout", {31'd0, send_ready}, 32'd1);
    @(negedge clk);
    check("R9 timeout single pulse", {31'd0, timeout}, 32'd0);

    // Synchronizer latency.
    cts_in = 1'b0;
    @(negedge clk);
    check("R8 one edge: still ready", {31'd0, send_ready}, 32'd1);
    @(negedge clk);
    check("R8 two edges: closed", {31'd0, send_ready}, 32'd0);
    cts_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 reopened", {31'd0, send_ready}, 32'd1);

    check("R3 scoreboard drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule